// File: doc/BRIEF.md
# Validity-Tagged Content-Addressable Memory with Next-Free Allocation

This block is a small content-addressable memory whose entries are each paired with a validity tag. A tag of 1 marks an entry as empty; a tag of 0 marks it as holding live data. Software or a controller drives one command per clock through a 3-bit opcode. The commands are:

- write or read an entry by its address;
- write into the next free entry;
- compare a 64-bit key against every live entry;
- force a tag to empty or to valid;
- load the device-select register.

The block keeps a match flag, a multiple-match flag and a full flag, all active low. It also keeps the address of the most recent result and the index of the lowest-numbered empty entry. These are packed into a 32-bit status word and a 32-bit next-free word, and both words carry the 4-bit page address of the device.

Entry 0 has the highest priority. Allocation through next-free writes therefore fills the array from entry 0 upward. When a key matches several entries, the lowest-numbered one is reported. Commands act only while the device is selected. The device is selected when either of two active-low select pins is low. It is also selected when the device-select register is enabled and its page field equals the page address.

Top module: `vcam_core`

## Requirements
- R1: An entry whose validity tag is 1 (empty) never matches in a compare, whatever its data, including data written with the tag set to 1 by op 1.
- R2: The next-free index is the lowest entry index whose tag is 1. When no entry is empty, the index equals DEPTH.
- R3: Op 3 (write next free) stores cmd_data at the next-free index and clears its tag to 0. On the following clock the status active address is that index and the result type is 01. With no empty entry, op 3 changes nothing.
- R4: Op 4 (compare) updates match_n and mmatch_n one clock later. match_n is 0 when at least one valid entry equals cmd_data. mmatch_n is 0 when at least two valid entries equal it. On a match, the active address becomes the lowest matching index and the result type becomes 00.
- R5: full_n is 0 only when every tag is 0 and full_in_n is 0.
- R6: The status word holds match_n in bit 30, mmatch_n in bit 29 and full_n in bit 28. Bits 25:24 hold the result type (00 = match, 01 = memory access, 10 = reset state). Bits 19:16 hold page_addr and bits 12:0 hold the active address. Every other bit is 0.
- R7: The next-free word holds page_addr in bits 19:16 and the next-free index, zero-extended, in bits 12:0. Every other bit is 0.
- R8: selected is 1 when cs_a_n is 0, or cs_b_n is 0, or the register page field equals page_addr while the register disable bit is 0.
- R9: Op 7 loads the register page field from cmd_data[3:0] and the disable bit from cmd_data[8], whether or not the device is selected. The disable bit set to 1 blocks selection through the register.
- R10: Op 1 writes cmd_data and the tag cmd_empty to entry cmd_addr. Op 2 returns that entry's data on rd_data and its tag on rd_empty one clock later. Both set the result type to 01 and the active address to cmd_addr. An address at or above DEPTH is ignored.
- R11: Op 5 sets the tag of entry cmd_addr to 1 and op 6 clears it to 0. Neither changes the result type or the active address.
- R12: After reset, every tag is 1, the result type is 10, the active address is 0, match_n and mmatch_n are 1, the next-free index is 0, and the register disable bit is 1.
- R13: A compare that finds no match sets match_n and mmatch_n to 1 and leaves the result type and the active address unchanged.
- R14: While selected is 0, ops 1 to 6 change no entry, tag, flag or status field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_a_n | input | 1 | Active-low select pin, shared by all devices |
| cs_b_n | input | 1 | Active-low select pin, decoded per device |
| page_addr | input | 4 | Page address of this device |
| full_in_n | input | 1 | Active-low full-in enable for the full flag |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Opcode (0 none, 1 write at, 2 read at, 3 write next free, 4 compare, 5 set empty, 6 set valid, 7 load select register) |
| cmd_addr | input | 13 | Entry address for ops 1, 2, 5, 6 |
| cmd_data | input | 64 | Write data, compare key, or select register value |
| cmd_empty | input | 1 | Tag written by op 1 (1 = empty) |
| rd_data | output | 64 | Data read by op 2 |
| rd_empty | output | 1 | Tag read by op 2 |
| match_n | output | 1 | Active-low match flag |
| mmatch_n | output | 1 | Active-low multiple-match flag |
| full_n | output | 1 | Active-low full flag |
| selected | output | 1 | Device is currently selected |
| status_word | output | 32 | Packed status word |
| nfree_word | output | 32 | Packed next-free word |

## Verification
The array is first filled entry by entry through next-free writes. This exposes the allocation order and the full flag under both settings of full-in. Each stored key is then compared in turn, so a wrong match index or a missed comparison shows up at the entry where it occurs. A duplicate key separates single matches from multiple matches. Tags are then emptied again, by force and through writes with the tag set to 1: this tells a filter that ignores the tag apart from one that honours it, and it moves the next-free index into the middle of the array. Finally, all sixteen combinations of the two select pins, the register disable bit and the page match are swept, and unselected writes are checked to leave the array untouched.

// File: rtl/vcam_pkg.sv
package vcam_pkg;
    localparam int AF_W = 13;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_WRITE_AT  = 3'd1,
        OP_READ_AT   = 3'd2,
        OP_WRITE_NF  = 3'd3,
        OP_COMPARE   = 3'd4,
        OP_SET_EMPTY = 3'd5,
        OP_SET_VALID = 3'd6,
        OP_LOAD_DSEL = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        RES_MATCH  = 2'b00,
        RES_ACCESS = 2'b01,
        RES_RESET  = 2'b10
    } res_e;
endpackage

// File: rtl/vcam_prio_enc.sv
module vcam_prio_enc #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Lowest index wins: scan from the top so the last hit written is the lowest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vcam_match_array.sv
module vcam_match_array #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 64
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] entries,
    input  logic [DEPTH-1:0]             empty,
    input  logic [DATA_W-1:0]            key,
    output logic [DEPTH-1:0]             hit,
    output logic                         any_hit,
    output logic                         multi_hit
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign hit[g] = !empty[g] && (entries[g] == key);
    end

    assign any_hit   = |hit;
    // Clearing the lowest set bit leaves something only if two or more were set.
    assign multi_hit = |(hit & (hit - DEPTH'(1)));
endmodule

// File: rtl/vcam_dev_select.sv
module vcam_dev_select (
    input  logic       cs_a_n,
    input  logic       cs_b_n,
    input  logic [3:0] page_addr,
    input  logic [3:0] reg_page,
    input  logic       reg_off,
    output logic       sel
);
    logic reg_hit;

    assign reg_hit = !reg_off && (reg_page == page_addr);
    assign sel     = !cs_a_n || !cs_b_n || reg_hit;
endmodule

// File: rtl/vcam_core.sv
module vcam_core
    import vcam_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [3:0]        page_addr,
    input  logic              full_in_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [AF_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_empty,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              match_n,
    output logic              mmatch_n,
    output logic              full_n,
    output logic              selected,
    output logic [31:0]       status_word,
    output logic [31:0]       nfree_word
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AF_W-1:0] DEPTH_F = AF_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DEPTH-1:0]             empty;
        logic [DATA_W-1:0]            rd_data;
        logic                         rd_empty;
        logic                         match_n;
        logic                         mmatch_n;
        res_e                         rtype;
        logic [AF_W-1:0]              act;
        logic [3:0]                   dsel_page;
        logic                         dsel_off;
    } state_t;

    state_t state_d, state_q;

    logic [DEPTH-1:0] hit;
    logic             any_hit, multi_hit;
    logic             nf_found, mt_found;
    logic [IDX_W-1:0] nf_idx, mt_idx;
    logic [AF_W-1:0]  nf_field, mt_field;
    logic             addr_ok;
    logic [IDX_W-1:0] addr_idx;

    vcam_match_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_match (
        .entries   (state_q.mem),
        .empty     (state_q.empty),
        .key       (cmd_data),
        .hit       (hit),
        .any_hit   (any_hit),
        .multi_hit (multi_hit)
    );

    vcam_prio_enc #(.N(DEPTH)) u_free_enc (
        .req   (state_q.empty),
        .found (nf_found),
        .idx   (nf_idx)
    );

    vcam_prio_enc #(.N(DEPTH)) u_hit_enc (
        .req   (hit),
        .found (mt_found),
        .idx   (mt_idx)
    );

    vcam_dev_select u_sel (
        .cs_a_n    (cs_a_n),
        .cs_b_n    (cs_b_n),
        .page_addr (page_addr),
        .reg_page  (state_q.dsel_page),
        .reg_off   (state_q.dsel_off),
        .sel       (selected)
    );

    assign nf_field = nf_found ? AF_W'(nf_idx) : DEPTH_F;
    assign mt_field = AF_W'(mt_idx);
    assign addr_ok  = cmd_addr < DEPTH_F;
    assign addr_idx = cmd_addr[IDX_W-1:0];

    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            if (op_e'(cmd_op) == OP_LOAD_DSEL) begin
                state_d.dsel_page = cmd_data[3:0];
                state_d.dsel_off  = cmd_data[8];
            end else if (selected) begin
                case (op_e'(cmd_op))
                    OP_WRITE_AT: if (addr_ok) begin
                        state_d.mem[addr_idx]   = cmd_data;
                        state_d.empty[addr_idx] = cmd_empty;
                        state_d.rtype           = RES_ACCESS;
                        state_d.act             = cmd_addr;
                    end
                    OP_READ_AT: if (addr_ok) begin
                        state_d.rd_data  = state_q.mem[addr_idx];
                        state_d.rd_empty = state_q.empty[addr_idx];
                        state_d.rtype    = RES_ACCESS;
                        state_d.act      = cmd_addr;
                    end
                    OP_WRITE_NF: if (nf_found) begin
                        state_d.mem[nf_idx]   = cmd_data;
                        state_d.empty[nf_idx] = 1'b0;
                        state_d.rtype         = RES_ACCESS;
                        state_d.act           = nf_field;
                    end
                    OP_COMPARE: begin
                        state_d.match_n  = !any_hit;
                        state_d.mmatch_n = !multi_hit;
                        if (mt_found) begin
                            state_d.rtype = RES_MATCH;
                            state_d.act   = mt_field;
                        end
                    end
                    OP_SET_EMPTY: if (addr_ok) state_d.empty[addr_idx] = 1'b1;
                    OP_SET_VALID: if (addr_ok) state_d.empty[addr_idx] = 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.mem       <= '0;
            state_q.empty     <= '1;
            state_q.rd_data   <= '0;
            state_q.rd_empty  <= 1'b1;
            state_q.match_n   <= 1'b1;
            state_q.mmatch_n  <= 1'b1;
            state_q.rtype     <= RES_RESET;
            state_q.act       <= '0;
            state_q.dsel_page <= '0;
            state_q.dsel_off  <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data  = state_q.rd_data;
    assign rd_empty = state_q.rd_empty;
    assign match_n  = state_q.match_n;
    assign mmatch_n = state_q.mmatch_n;
    assign full_n   = !((~|state_q.empty) && !full_in_n);

    assign status_word = {1'b0, state_q.match_n, state_q.mmatch_n, full_n,
                          2'b00, state_q.rtype, 4'b0000, page_addr,
                          3'b000, state_q.act};
    assign nfree_word  = {12'h000, page_addr, 3'b000, nf_field};
endmodule

// File: rtl/vcam_checker.sv
module vcam_checker #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        full_in_n,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic [3:0]  page_addr,
    input logic        match_n,
    input logic        mmatch_n,
    input logic        full_n,
    input logic        selected,
    input logic [31:0] status_word,
    input logic [31:0] nfree_word
);
    localparam logic [12:0] DEPTH_F = 13'(DEPTH);

    p_mm_implies_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mmatch_n |-> !match_n);

    p_full_needs_fin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !full_in_n);

    p_status_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & 32'h8CF0_E000) == 32'h0 && status_word[19:16] == page_addr);

    p_nfree_layout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nfree_word[31:20] == 12'h0 && nfree_word[15:13] == 3'b000
        && nfree_word[19:16] == page_addr && nfree_word[12:0] <= DEPTH_F);

    p_nf_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3 && selected && nfree_word[12:0] != DEPTH_F)
        |=> (status_word[12:0] == $past(nfree_word[12:0]) && status_word[25:24] == 2'b01));

    p_unselected_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 3'd7 && !selected)
        |=> ($stable(status_word[25:24]) && $stable(status_word[12:0])
             && $stable(nfree_word[12:0]) && $stable(match_n)));
endmodule

bind vcam_core vcam_checker #(.DEPTH(DEPTH)) u_vcam_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_in_n   (full_in_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .page_addr   (page_addr),
    .match_n     (match_n),
    .mmatch_n    (mmatch_n),
    .full_n      (full_n),
    .selected    (selected),
    .status_word (status_word),
    .nfree_word  (nfree_word)
);

// File: tb/vcam_core_test.sv
module vcam_core_test;
    localparam int D = 16;
    localparam logic [3:0] PAGE = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_a_n = 1'b1, cs_b_n = 1'b1;
    logic [3:0]  page_addr = PAGE;
    logic        full_in_n = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [12:0] cmd_addr = '0;
    logic [63:0] cmd_data = '0;
    logic        cmd_empty = 1'b0;
    logic [63:0] rd_data;
    logic        rd_empty, match_n, mmatch_n, full_n, selected;
    logic [31:0] status_word, nfree_word;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [63:0] md [D];
    logic        me [D];
    logic [1:0]  e_type = 2'b10;
    logic [12:0] e_act = '0;
    logic        e_mn = 1'b1, e_mmn = 1'b1;
    logic [63:0] e_rd = '0;
    logic        e_rde = 1'b1;
    logic [3:0]  m_dpage = '0;
    logic        m_doff = 1'b1;

    always #4 clk = ~clk;

    vcam_core uut (
        .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .page_addr(page_addr), .full_in_n(full_in_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_empty(cmd_empty), .rd_data(rd_data), .rd_empty(rd_empty),
        .match_n(match_n), .mmatch_n(mmatch_n), .full_n(full_n),
        .selected(selected), .status_word(status_word), .nfree_word(nfree_word)
    );

    function automatic logic [63:0] dval(input int i);
        return 64'hC0DE_0000_0000_0000 | (64'(i + 1) * 64'h0001_0003_0005_0007);
    endfunction

    function automatic int model_nf();
        for (int i = 0; i < D; i++) if (me[i]) return i;
        return D;
    endfunction

    function automatic logic model_full_n();
        for (int i = 0; i < D; i++) if (me[i]) return 1'b1;
        return full_in_n;
    endfunction

    function automatic logic model_sel();
        return !cs_a_n || !cs_b_n || (m_dpage == page_addr && !m_doff);
    endfunction

    task automatic check(input string lbl, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
        end
    endtask

    task automatic check_state(input string lbl);
        logic [31:0] es, en;
        logic        efn;
        efn = model_full_n();
        es = 32'h0;
        es[30] = e_mn; es[29] = e_mmn; es[28] = efn;
        es[25:24] = e_type; es[19:16] = page_addr; es[12:0] = e_act;
        en = 32'h0;
        en[19:16] = page_addr; en[12:0] = 13'(model_nf());
        check({lbl, " status"}, 64'(status_word), 64'(es));
        check({lbl, " nfree"}, 64'(nfree_word), 64'(en));
        check({lbl, " flags"}, {61'h0, match_n, mmatch_n, full_n}, {61'h0, e_mn, e_mmn, efn});
    endtask

    task automatic issue(input logic [2:0] op, input logic [12:0] addr,
                         input logic [63:0] data, input logic emp);
        logic sel;
        int   nf, cnt, first;
        sel = model_sel();
        @(negedge clk);
        cmd_op = op; cmd_addr = addr; cmd_data = data; cmd_empty = emp; cmd_valid = 1'b1;
        if (op == 3'd7) begin
            m_dpage = data[3:0];
            m_doff  = data[8];
        end else if (sel) begin
            case (op)
                3'd1: if (addr < D) begin md[addr] = data; me[addr] = emp; e_type = 2'b01; e_act = addr; end
                3'd2: if (addr < D) begin e_rd = md[addr]; e_rde = me[addr]; e_type = 2'b01; e_act = addr; end
                3'd3: begin
                    nf = model_nf();
                    if (nf < D) begin md[nf] = data; me[nf] = 1'b0; e_type = 2'b01; e_act = 13'(nf); end
                end
                3'd4: begin
                    cnt = 0; first = -1;
                    for (int i = 0; i < D; i++)
                        if (!me[i] && md[i] == data) begin
                            cnt++;
                            if (first < 0) first = i;
                        end
                    e_mn = (cnt == 0); e_mmn = (cnt < 2);
                    if (cnt > 0) begin e_type = 2'b00; e_act = 13'(first); end
                end
                3'd5: if (addr < D) me[addr] = 1'b1;
                3'd6: if (addr < D) me[addr] = 1'b0;
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < D; i++) begin md[i] = '0; me[i] = 1'b1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12: reset state
        check_state("R12 reset");
        check("R12 selected after reset", 64'(selected), 64'(0));

        cs_a_n = 1'b0;
        // R3 / R2: fill through next-free writes
        for (int i = 0; i < D; i++) begin
            check("R2 nf before write", 64'(nfree_word[12:0]), 64'(i));
            issue(3'd3, 13'd0, dval(i), 1'b0);
            check("R3 status after nf write", 64'(status_word[12:0]), 64'(i));
            check_state("R3 fill");
        end
        // R5: full only with full-in low
        check("R5 full_n with full_in_n high", 64'(full_n), 64'(1));
        full_in_n = 1'b0; #1;
        check("R5 full_n with full_in_n low", 64'(full_n), 64'(0));
        // R3: write next free while full is ignored
        issue(3'd3, 13'd0, 64'hDEAD_BEEF, 1'b0);
        issue(3'd2, 13'd0, '0, 1'b0);
        check("R3 full write ignored", rd_data, dval(0));
        check_state("R3 full");

        // R4: compare each key
        for (int i = 0; i < D; i++) begin
            issue(3'd4, 13'd0, dval(i), 1'b0);
            check("R4 single match", {62'h0, match_n, mmatch_n}, {62'h0, 1'b0, 1'b1});
            check_state("R4 compare");
        end
        // R13: miss leaves type and address
        issue(3'd4, 13'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        check("R13 miss keeps address", 64'(status_word[12:0]), 64'(D - 1));
        check_state("R13 miss");

        // R4 multiple match with duplicate
        issue(3'd1, 13'd9, dval(3), 1'b0);
        issue(3'd4, 13'd0, dval(3), 1'b0);
        check("R4 multiple match", {62'h0, match_n, mmatch_n}, 64'h0);
        check("R4 lowest index", 64'(status_word[12:0]), 64'd3);
        check_state("R4 multi");

        // R11 / R1: emptied entries drop out of comparison
        full_in_n = 1'b1;
        issue(3'd5, 13'd3, '0, 1'b0);
        check("R11 set empty keeps status", 64'(status_word[12:0]), 64'd3);
        check("R2 nf after set empty", 64'(nfree_word[12:0]), 64'd3);
        issue(3'd4, 13'd0, dval(3), 1'b0);
        check("R1 empty entry skipped", 64'(status_word[12:0]), 64'd9);
        check_state("R1 partial");
        issue(3'd1, 13'd9, dval(3), 1'b1);
        issue(3'd4, 13'd0, dval(3), 1'b0);
        check("R1 written-empty no match", 64'(match_n), 64'd1);
        check_state("R1 none");
        issue(3'd6, 13'd3, '0, 1'b0);
        issue(3'd4, 13'd0, dval(3), 1'b0);
        check("R11 set valid rematches", 64'(status_word[12:0]), 64'd3);
        check_state("R11 valid");

        // R10: read every entry
        for (int i = 0; i < D; i++) begin
            issue(3'd2, 13'(i), '0, 1'b0);
            check("R10 read data", rd_data, e_rd);
            check("R10 read tag", 64'(rd_empty), 64'(e_rde));
            check_state("R10 read");
        end
        issue(3'd2, 13'd20, '0, 1'b0);
        check("R10 out of range read ignored", rd_data, md[D - 1]);
        check_state("R10 range");

        // R14: unselected commands ignored
        cs_a_n = 1'b1; #1;
        check("R14 deselected", 64'(selected), 64'd0);
        issue(3'd1, 13'd0, 64'h1234, 1'b0);
        issue(3'd5, 13'd1, '0, 1'b0);
        check_state("R14 unselected");
        cs_b_n = 1'b0;
        issue(3'd2, 13'd0, '0, 1'b0);
        check("R14 entry 0 kept", rd_data, dval(0));
        check("R14 nf unchanged", 64'(nfree_word[12:0]), 64'(model_nf()));
        cs_b_n = 1'b1;

        // R8 / R9: select sweep
        for (int k = 0; k < 16; k++) begin
            logic [63:0] rv;
            rv = '0;
            rv[3:0] = k[2] ? PAGE : 4'hA;
            rv[8] = k[3];
            cs_a_n = 1'b1; cs_b_n = 1'b1;
            issue(3'd7, 13'd0, rv, 1'b0);
            cs_a_n = k[0]; cs_b_n = k[1];
            #1;
            check("R8 R9 select sweep", 64'(selected),
                  64'(!k[0] || !k[1] || (k[2] && !k[3])));
        end
        // R9: register-only selection enables writes
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        issue(3'd7, 13'd0, 64'(PAGE), 1'b0);
        issue(3'd1, 13'd2, 64'h55AA, 1'b0);
        issue(3'd2, 13'd2, '0, 1'b0);
        check("R9 register select write", rd_data, 64'h55AA);
        check_state("R9 reg");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule